// File: doc/BRIEF.md
# Slotted Delay-Line Contention Scheduler

This block is the control logic of a slot-synchronous packet switch that owns a small pool of recirculating delay lines. Every clock cycle is one slot. In that slot the block gathers the new requests from its inputs, each naming an output port, together with the packets that come back out of the delay lines. It then grants each output port to at most one contender. A packet that loses is either parked in a free delay line, which hands it back one slot later, or dropped.

Each delay line holds exactly one packet for exactly one slot. The block tracks every line in a status table with a busy flag, the port its packet is waiting for, and the number of passes the packet has made so far. Contention is settled oldest first. A packet may only be parked again while its pass count is below a configured limit. A saturating counter records every drop.

Top module: `dl_contention_sched`

## Requirements
- R1: After reset the status table is empty (all busy flags 0), the drop counter is 0, and no port is granted while no request is present.
- R2: A valid request to an output port that nobody else wants in that slot is granted in the same slot. `port_grant` for that port is 1, and `port_src` for that port is N_LINE plus the input index (returning lines use source codes 0 to N_LINE-1).
- R3: Each output port is granted to at most one contender per slot. Among new requests with no returning packet for that port, the lowest input index wins.
- R4: A loser whose pass count is below MAX_CIRC is parked in the lowest-indexed line still free in that slot. From the next slot the table shows that line busy, with the loser's port and a pass count one higher than before.
- R5: A parked packet contends again in the very next slot. Its line is free again in that same slot and can be handed to a new loser.
- R6: Priority follows pass count, higher first. A returning packet therefore beats a new request for the same port, and among equal counts the lower source code wins.
- R7: A loser whose pass count already equals MAX_CIRC is dropped (`ret_drop`) and leaves the table.
- R8: Losers take lines in ascending source-code order: returning packets by line index first, then new requests by input index. Losers that find every line taken are dropped.
- R9: The drop counter adds the number of packets dropped in a slot one cycle later and saturates at its all-ones value.
- R10: A request naming a port index of N_PORT or above is discarded. It gets no grant, no line and no drop count, and it leaves the table unchanged.
- R11: Every valid request to an existing port receives exactly one of grant, line or drop in its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_IN | Request present per input |
| req_port | input | N_IN*PW | Destination port per input |
| in_grant | output | N_IN | Input granted its port this slot |
| in_to_line | output | N_IN | Input parked in a delay line |
| in_line_idx | output | N_IN*LW | Line index used by each parked input |
| in_drop | output | N_IN | Input dropped this slot |
| ret_grant | output | N_LINE | Returning packet of line granted |
| ret_drop | output | N_LINE | Returning packet of line dropped |
| port_grant | output | N_PORT | Port granted this slot |
| port_src | output | N_PORT*SW | Source code of each port's winner |
| line_busy | output | N_LINE | Status table busy flags |
| line_port | output | N_LINE*PW | Status table target ports |
| line_delay | output | N_LINE*CW | Status table pass counts |
| drop_count | output | DROP_W | Saturating drop counter |

## Verification
The bench uses single requests to separate the grant path from arbitration. It uses pairs of requests to one port to show parking and the return of the packet one slot later, where the returning packet beats a fresh request. A burst of four requests to one port, with the limit set to two passes, steps packets through increasing pass counts until the limit forces a drop. Repeating the burst while lines are still busy overfills the pool and shows the allocation order. Mixed destinations check that independent ports are granted in parallel. Out-of-range ports check the discard rule. A long saturating burst checks that each request gets exactly one outcome and that the counter clamps.

// File: rtl/dl_sched_pkg.sv
package dl_sched_pkg;

  typedef enum logic [1:0] {
    OC_IDLE  = 2'd0,
    OC_GRANT = 2'd1,
    OC_PARK  = 2'd2,
    OC_DROP  = 2'd3
  } outcome_e;

  function automatic int wid(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dl_rst_sync.sv
module dl_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/dl_port_arb.sv
module dl_port_arb #(
  parameter int NC      = 8,
  parameter int PW      = 3,
  parameter int CW      = 2,
  parameter int SW      = 3,
  parameter int PORT_ID = 0
) (
  input  logic [NC-1:0]    cvalid,
  input  logic [NC*PW-1:0] cport,
  input  logic [NC*CW-1:0] cdelay,
  output logic [NC-1:0]    win_oh,
  output logic             hit,
  output logic [SW-1:0]    sel
);

  logic [NC-1:0] want;
  logic [CW-1:0] best_d;
  int            best;
  logic          found;

  // oldest first; strict compare keeps the lowest source code on a tie
  always_comb begin
    found  = 1'b0;
    best   = 0;
    best_d = '0;
    for (int c = 0; c < NC; c++) begin
      want[c] = cvalid[c] && (cport[c*PW +: PW] == PW'(PORT_ID));
      if (want[c] && (!found || (cdelay[c*CW +: CW] > best_d))) begin
        found  = 1'b1;
        best   = c;
        best_d = cdelay[c*CW +: CW];
      end
    end
    for (int c = 0; c < NC; c++) begin
      win_oh[c] = found && (best == c);
    end
  end

  assign hit = found;
  assign sel = SW'(best);

endmodule

// File: rtl/dl_line_alloc.sv
module dl_line_alloc
  import dl_sched_pkg::*;
#(
  parameter int NC       = 8,
  parameter int N_LINE   = 4,
  parameter int LW       = 2,
  parameter int CW       = 2,
  parameter int SW       = 3,
  parameter int DCW      = 4,
  parameter int MAX_CIRC = 3
) (
  input  logic [NC-1:0]    cvalid,
  input  logic [NC-1:0]    win,
  input  logic [NC*CW-1:0] cdelay,
  output outcome_e         outcome   [NC],
  output logic [LW-1:0]    line_idx  [NC],
  output logic [N_LINE-1:0] line_take,
  output logic [SW-1:0]    line_from [N_LINE],
  output logic [DCW-1:0]   slot_drops
);

  localparam logic [CW-1:0] MAX_D = CW'(MAX_CIRC);

  logic placed;

  // losers scanned in source-code order, each taking the lowest free line
  always_comb begin
    line_take  = '0;
    slot_drops = '0;
    placed     = 1'b0;
    for (int l = 0; l < N_LINE; l++) begin
      line_from[l] = '0;
    end
    for (int c = 0; c < NC; c++) begin
      outcome[c]  = OC_IDLE;
      line_idx[c] = '0;
      placed      = 1'b0;
      if (cvalid[c]) begin
        if (win[c]) begin
          outcome[c] = OC_GRANT;
        end else begin
          if (cdelay[c*CW +: CW] < MAX_D) begin
            for (int l = 0; l < N_LINE; l++) begin
              if (!placed && !line_take[l]) begin
                placed       = 1'b1;
                line_take[l] = 1'b1;
                line_from[l] = SW'(c);
                line_idx[c]  = LW'(l);
              end
            end
          end
          if (placed) begin
            outcome[c] = OC_PARK;
          end else begin
            outcome[c] = OC_DROP;
            slot_drops = slot_drops + DCW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/dl_status_table.sv
module dl_status_table #(
  parameter int N_LINE   = 4,
  parameter int NC       = 8,
  parameter int PW       = 3,
  parameter int CW       = 2,
  parameter int SW       = 3,
  parameter int DCW      = 4,
  parameter int DROP_W   = 16,
  parameter int MAX_CIRC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINE-1:0]    line_take,
  input  logic [SW-1:0]        line_from [N_LINE],
  input  logic [NC*PW-1:0]     cport,
  input  logic [NC*CW-1:0]     cdelay,
  input  logic [DCW-1:0]       slot_drops,
  output logic [N_LINE-1:0]    busy_q,
  output logic [N_LINE*PW-1:0] port_q,
  output logic [N_LINE*CW-1:0] delay_q,
  output logic [DROP_W-1:0]    drop_q
);

  logic [N_LINE*PW-1:0] port_d;
  logic [N_LINE*CW-1:0] delay_d;
  logic [DROP_W:0]      drop_sum;
  logic [DROP_W-1:0]    drop_d;
  logic                 drop_en;

  // next state: every line empties each slot, refilled only by a loser
  always_comb begin
    for (int l = 0; l < N_LINE; l++) begin
      port_d[l*PW +: PW]  = '0;
      delay_d[l*CW +: CW] = '0;
      for (int c = 0; c < NC; c++) begin
        if (line_take[l] && (line_from[l] == SW'(c))) begin
          port_d[l*PW +: PW]  = cport[c*PW +: PW];
          delay_d[l*CW +: CW] = cdelay[c*CW +: CW] + CW'(1);
        end
      end
    end
    drop_sum = {1'b0, drop_q} + (DROP_W+1)'(slot_drops);
    drop_d   = drop_sum[DROP_W] ? '1 : drop_sum[DROP_W-1:0];
    drop_en  = (slot_drops != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      port_q  <= '0;
      delay_q <= '0;
      drop_q  <= '0;
    end else begin
      busy_q <= line_take;
      for (int l = 0; l < N_LINE; l++) begin
        if (line_take[l]) begin
          port_q[l*PW +: PW]  <= port_d[l*PW +: PW];
          delay_q[l*CW +: CW] <= delay_d[l*CW +: CW];
        end
      end
      if (drop_en) begin
        drop_q <= drop_d;
      end
    end
  end

  // R9
  // drop_mono_chk
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_q >= $past(drop_q)));

  for (genvar l = 0; l < N_LINE; l++) begin : g_dchk
    // R7
    // delay_range_chk
    delay_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[l] |-> ((delay_q[l*CW +: CW] != '0) &&
                     (delay_q[l*CW +: CW] <= CW'(MAX_CIRC))));
  end

endmodule

// File: rtl/dl_contention_sched.sv
module dl_contention_sched
  import dl_sched_pkg::*;
#(
  parameter int N_IN     = 4,
  parameter int N_PORT   = 5,
  parameter int N_LINE   = 4,
  parameter int MAX_CIRC = 3,
  parameter int DROP_W   = 16,
  localparam int NC      = N_LINE + N_IN,
  localparam int PW      = wid(N_PORT),
  localparam int LW      = wid(N_LINE),
  localparam int CW      = wid(MAX_CIRC + 1),
  localparam int SW      = wid(NC),
  localparam int DCW     = $clog2(NC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_IN-1:0]      req_valid,
  input  logic [N_IN*PW-1:0]   req_port,
  output logic [N_IN-1:0]      in_grant,
  output logic [N_IN-1:0]      in_to_line,
  output logic [N_IN*LW-1:0]   in_line_idx,
  output logic [N_IN-1:0]      in_drop,
  output logic [N_LINE-1:0]    ret_grant,
  output logic [N_LINE-1:0]    ret_drop,
  output logic [N_PORT-1:0]    port_grant,
  output logic [N_PORT*SW-1:0] port_src,
  output logic [N_LINE-1:0]    line_busy,
  output logic [N_LINE*PW-1:0] line_port,
  output logic [N_LINE*CW-1:0] line_delay,
  output logic [DROP_W-1:0]    drop_count
);

  logic rst_q;

  dl_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  logic [NC-1:0]     cvalid;
  logic [NC*PW-1:0]  cport;
  logic [NC*CW-1:0]  cdelay;
  logic [N_IN-1:0]   oor;

  // contenders: returning lines take codes 0..N_LINE-1, inputs follow
  always_comb begin
    for (int l = 0; l < N_LINE; l++) begin
      cvalid[l]           = line_busy[l];
      cport[l*PW +: PW]   = line_port[l*PW +: PW];
      cdelay[l*CW +: CW]  = line_delay[l*CW +: CW];
    end
    for (int i = 0; i < N_IN; i++) begin
      oor[i] = req_valid[i] &&
               ({1'b0, req_port[i*PW +: PW]} >= (PW+1)'(N_PORT));
      cvalid[N_LINE+i]            = req_valid[i] && !oor[i];
      cport[(N_LINE+i)*PW +: PW]  = req_port[i*PW +: PW];
      cdelay[(N_LINE+i)*CW +: CW] = '0;
    end
  end

  logic [NC-1:0] win_p [N_PORT];
  logic [NC-1:0] win;

  for (genvar p = 0; p < N_PORT; p++) begin : g_arb
    dl_port_arb #(
      .NC      (NC),
      .PW      (PW),
      .CW      (CW),
      .SW      (SW),
      .PORT_ID (p)
    ) u_arb (
      .cvalid (cvalid),
      .cport  (cport),
      .cdelay (cdelay),
      .win_oh (win_p[p]),
      .hit    (port_grant[p]),
      .sel    (port_src[p*SW +: SW])
    );
  end

  always_comb begin
    win = '0;
    for (int p = 0; p < N_PORT; p++) begin
      win = win | win_p[p];
    end
  end

  outcome_e          outcome   [NC];
  logic [LW-1:0]     line_idx  [NC];
  logic [N_LINE-1:0] line_take;
  logic [SW-1:0]     line_from [N_LINE];
  logic [DCW-1:0]    slot_drops;

  dl_line_alloc #(
    .NC       (NC),
    .N_LINE   (N_LINE),
    .LW       (LW),
    .CW       (CW),
    .SW       (SW),
    .DCW      (DCW),
    .MAX_CIRC (MAX_CIRC)
  ) u_alloc (
    .cvalid     (cvalid),
    .win        (win),
    .cdelay     (cdelay),
    .outcome    (outcome),
    .line_idx   (line_idx),
    .line_take  (line_take),
    .line_from  (line_from),
    .slot_drops (slot_drops)
  );

  dl_status_table #(
    .N_LINE   (N_LINE),
    .NC       (NC),
    .PW       (PW),
    .CW       (CW),
    .SW       (SW),
    .DCW      (DCW),
    .DROP_W   (DROP_W),
    .MAX_CIRC (MAX_CIRC)
  ) u_tab (
    .clk        (clk),
    .rst_n      (rst_q),
    .line_take  (line_take),
    .line_from  (line_from),
    .cport      (cport),
    .cdelay     (cdelay),
    .slot_drops (slot_drops),
    .busy_q     (line_busy),
    .port_q     (line_port),
    .delay_q    (line_delay),
    .drop_q     (drop_count)
  );

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      in_grant[i]               = (outcome[N_LINE+i] == OC_GRANT);
      in_to_line[i]             = (outcome[N_LINE+i] == OC_PARK);
      in_drop[i]                = (outcome[N_LINE+i] == OC_DROP);
      in_line_idx[i*LW +: LW]   = line_idx[N_LINE+i];
    end
    for (int l = 0; l < N_LINE; l++) begin
      ret_grant[l] = (outcome[l] == OC_GRANT);
      ret_drop[l]  = (outcome[l] == OC_DROP);
    end
  end

  // R3
  // grant_count_chk
  grant_count_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($countones({in_grant, ret_grant}) == $countones(port_grant)));

  // R8
  // no_idle_line_chk
  no_idle_line_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((|in_drop) && (MAX_CIRC > 0)) |=> (&line_busy));

  // R4
  // line_fill_chk
  line_fill_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (|in_to_line) |=> (|line_busy));

  // R10
  // oor_ignore_chk
  oor_ignore_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((oor & (in_grant | in_to_line | in_drop)) == '0));

endmodule

// File: tb/dl_contention_sched_bench.sv
module dl_contention_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 4, N_PORT = 5, N_LINE = 4, MAX_CIRC = 2, DROP_W = 4;
  localparam int PW = 3, LW = 2, CW = 2, SW = 3;

  logic                 clk;
  logic                 rst_n;
  logic [N_IN-1:0]      req_valid;
  logic [N_IN*PW-1:0]   req_port;
  logic [N_IN-1:0]      in_grant, in_to_line, in_drop;
  logic [N_IN*LW-1:0]   in_line_idx;
  logic [N_LINE-1:0]    ret_grant, ret_drop, line_busy;
  logic [N_PORT-1:0]    port_grant;
  logic [N_PORT*SW-1:0] port_src;
  logic [N_LINE*PW-1:0] line_port;
  logic [N_LINE*CW-1:0] line_delay;
  logic [DROP_W-1:0]    drop_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  dl_contention_sched #(
    .N_IN(N_IN), .N_PORT(N_PORT), .N_LINE(N_LINE),
    .MAX_CIRC(MAX_CIRC), .DROP_W(DROP_W)
  ) u_dl_contention_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .in_grant(in_grant), .in_to_line(in_to_line), .in_line_idx(in_line_idx),
    .in_drop(in_drop), .ret_grant(ret_grant), .ret_drop(ret_drop),
    .port_grant(port_grant), .port_src(port_src), .line_busy(line_busy),
    .line_port(line_port), .line_delay(line_delay), .drop_count(drop_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int idx_of(input int i);  return int'(in_line_idx[i*LW +: LW]); endfunction
  function automatic int src_of(input int p);  return int'(port_src[p*SW +: SW]);   endfunction
  function automatic int lport(input int l);   return int'(line_port[l*PW +: PW]);  endfunction
  function automatic int ldly(input int l);    return int'(line_delay[l*CW +: CW]); endfunction

  // one slot: drive at the falling edge, outcomes settle before the rising edge
  task automatic apply(input logic [3:0] v, input int a, input int b, input int c, input int d);
    @(negedge clk);
    req_valid = v;
    req_port  = {PW'(d), PW'(c), PW'(b), PW'(a)};
    #1;
  endtask

  task automatic t_reset();
    apply(4'b0000, 0, 0, 0, 0);
    chk("R1", "line_busy", int'(line_busy), 0);
    chk("R1", "drop_count", int'(drop_count), 0);
    chk("R1", "port_grant", int'(port_grant), 0);
  endtask

  task automatic t_single();
    apply(4'b0100, 0, 0, 3, 0);
    chk("R2", "in_grant", int'(in_grant), 4'b0100);
    chk("R2", "port_grant", int'(port_grant), 5'b01000);
    chk("R2", "port_src[3]", src_of(3), 6);
    apply(4'b0000, 0, 0, 0, 0);
    chk("R2", "line_busy after", int'(line_busy), 0);
  endtask

  task automatic t_contend();
    apply(4'b0011, 1, 1, 0, 0);
    chk("R3", "in_grant", int'(in_grant), 4'b0001);
    chk("R4", "in_to_line", int'(in_to_line), 4'b0010);
    chk("R4", "idx in1", idx_of(1), 0);
    apply(4'b1000, 0, 0, 0, 1);
    chk("R4", "line_busy", int'(line_busy), 4'b0001);
    chk("R4", "line_port0", lport(0), 1);
    chk("R4", "line_delay0", ldly(0), 1);
    chk("R6", "ret_grant", int'(ret_grant), 4'b0001);
    chk("R6", "port_src[1]", src_of(1), 0);
    chk("R5", "in_to_line", int'(in_to_line), 4'b1000);
    chk("R5", "idx in3 reuses line0", idx_of(3), 0);
    apply(4'b0000, 0, 0, 0, 0);
    chk("R5", "line_delay0", ldly(0), 1);
    chk("R5", "ret_grant", int'(ret_grant), 4'b0001);
    apply(4'b0000, 0, 0, 0, 0);
    chk("R5", "line_busy empty", int'(line_busy), 0);
  endtask

  task automatic t_mixed();
    apply(4'b1111, 0, 1, 0, 4);
    chk("R3", "in_grant", int'(in_grant), 4'b1011);
    chk("R3", "port_grant", int'(port_grant), 5'b10011);
    chk("R3", "port_src[0]", src_of(0), 4);
    chk("R3", "port_src[4]", src_of(4), 7);
    chk("R4", "in_to_line", int'(in_to_line), 4'b0100);
    apply(4'b0000, 0, 0, 0, 0);
    chk("R5", "ret_grant", int'(ret_grant), 4'b0001);
    chk("R5", "port_grant", int'(port_grant), 5'b00001);
    apply(4'b0000, 0, 0, 0, 0);
  endtask

  task automatic t_maxcirc();
    apply(4'b1111, 0, 0, 0, 0);
    chk("R4", "in_to_line", int'(in_to_line), 4'b1110);
    chk("R4", "idx in3", idx_of(3), 2);
    apply(4'b0000, 0, 0, 0, 0);
    chk("R6", "ret_grant equal delays", int'(ret_grant), 4'b0001);
    chk("R7", "ret_drop none", int'(ret_drop), 0);
    apply(4'b0000, 0, 0, 0, 0);
    chk("R7", "line_busy", int'(line_busy), 4'b0011);
    chk("R7", "line_delay1", ldly(1), 2);
    chk("R7", "ret_drop at limit", int'(ret_drop), 4'b0010);
    apply(4'b0000, 0, 0, 0, 0);
    chk("R7", "table empty", int'(line_busy), 0);
    chk("R9", "drop_count", int'(drop_count), 1);
  endtask

  task automatic t_overflow();
    apply(4'b1111, 2, 2, 2, 2);
    apply(4'b1111, 2, 2, 2, 2);
    chk("R6", "ret_grant", int'(ret_grant), 4'b0001);
    chk("R8", "in_to_line", int'(in_to_line), 4'b0011);
    chk("R8", "idx in0", idx_of(0), 2);
    chk("R8", "idx in1", idx_of(1), 3);
    chk("R8", "in_drop", int'(in_drop), 4'b1100);
    apply(4'b0000, 0, 0, 0, 0);
    chk("R8", "line_busy full", int'(line_busy), 4'b1111);
    chk("R8", "line_delay0", ldly(0), 2);
    chk("R8", "line_delay2", ldly(2), 1);
    chk("R9", "drop_count", int'(drop_count), 3);
    chk("R7", "ret_drop", int'(ret_drop), 4'b0010);
    apply(4'b0000, 0, 0, 0, 0);
    chk("R9", "drop_count", int'(drop_count), 4);
  endtask

  task automatic t_range();
    apply(4'b0111, 5, 7, 3, 0);
    chk("R9", "drop_count", int'(drop_count), 5);
    chk("R10", "in_grant", int'(in_grant), 4'b0100);
    chk("R10", "in_to_line", int'(in_to_line), 0);
    chk("R10", "in_drop", int'(in_drop), 0);
    chk("R10", "port_grant", int'(port_grant), 5'b01000);
    apply(4'b0000, 0, 0, 0, 0);
    chk("R10", "line_busy", int'(line_busy), 0);
    chk("R10", "drop_count", int'(drop_count), 5);
  endtask

  task automatic t_saturate();
    for (int s = 0; s < 30; s++) begin
      apply(4'b1111, 4, 4, 4, 4);
      for (int i = 0; i < N_IN; i++) begin
        chk("R11", "one outcome",
            int'(in_grant[i]) + int'(in_to_line[i]) + int'(in_drop[i]), 1);
      end
    end
    apply(4'b0000, 0, 0, 0, 0);
    chk("R9", "saturated", int'(drop_count), 15);
    for (int s = 0; s < 6; s++) apply(4'b0000, 0, 0, 0, 0);
    chk("R9", "still saturated", int'(drop_count), 15);
    chk("R5", "drained", int'(line_busy), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = '0;
    req_port = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_contend();
    t_mixed();
    t_maxcirc();
    t_overflow();
    t_range();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule